// File: doc/BRIEF.md
# Configurable SPI Master/Slave Byte Transceiver

This block moves one byte in each direction per transfer over a synchronous serial link. The same logic serves as the clock source (master) or follows a clock from the far end (slave). Software-visible behaviour is set by static configuration inputs:

- clock polarity;
- MSB-first or LSB-first ordering;
- the level the serial output settles to once a byte is done;
- a 0 to 3 system-clock hold-off on every serial output change;
- in master mode, the serial clock rate.

In master mode a start pulse loads the transmit byte and produces eight clock pulses. In slave mode the start pulse preloads the byte that the external master will clock out. In 4-wire slave operation an active-low select qualifies the external clock. In 3-wire slave operation the select is ignored. Each finished byte lands in a receive register and raises a full flag, which stays up until it is acknowledged.

Top module: `spi_xcvr`

## Requirements
- R1: A master transfer shifts the 8 bits of `tx_data` out on `sdo` while it shifts 8 bits from `sdi` into `rx_data`. `busy` is high from the cycle after `tx_start` until the byte completes.
- R2: In master mode `sck_out` rests at `cfg_cpol` when idle. A transfer makes exactly 8 pulses with a period of 2^(`cfg_div`+1) system clocks (`cfg_div` 0,1,2,3 gives 2,4,8,16).
- R3: Incoming data is sampled on the edge that leaves the rest level. Outgoing data changes on the edge that returns to it. This holds for both values of `cfg_cpol`.
- R4: With `cfg_lsb_first`=0 bit 7 travels first in both directions. With 1, bit 0 travels first. `rx_data` always holds the byte in its natural bit positions.
- R5: Outside a transfer, and from the last data bit on, `sdo` sits at `cfg_sdo_idle`.
- R6: Every `sdo` change follows the internal shift edge by exactly `cfg_sdo_dly` system clocks (0 to 3).
- R7: When a byte completes, `rx_data` is loaded and `rx_full` rises. It stays high until a cycle with `rd_ack` high clears it. `rx_data` changes only at such a load.
- R8: With `cfg_master`=0, `sck_oe` is low and the transfer follows the edges of `sck_in`. The byte preloaded with `tx_start` is sent on `sdo` and the byte on `sdi` is received.
- R9: In 4-wire slave mode (`cfg_four_wire`=1), edges on `sck_in` are ignored while `ss_n_in` is high. Raising `ss_n_in` in mid-byte aborts the byte: the bit count returns to zero, `busy` drops and `rx_full` stays clear.
- R10: In 3-wire slave mode (`cfg_four_wire`=0), `ss_n_in` has no effect and bytes complete on `sck_in` edges alone.
- R11: A `tx_start` pulse during a master transfer is ignored. The byte in progress completes unchanged and only one byte is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = generate the serial clock, 0 = follow `sck_in` |
| cfg_four_wire | input | 1 | Slave honours `ss_n_in` when 1 |
| cfg_cpol | input | 1 | Rest level of the serial clock |
| cfg_lsb_first | input | 1 | Bit order select, 1 = LSB first |
| cfg_sdo_idle | input | 1 | Level of `sdo` outside a transfer |
| cfg_sdo_dly | input | DLY_W | System clocks between shift edge and `sdo` change |
| cfg_div | input | DIV_W | Master clock rate, period 2^(cfg_div+1) clocks |
| tx_data | input | 8 | Byte to transmit |
| tx_start | input | 1 | Master: start a transfer. Slave: preload `tx_data` |
| rd_ack | input | 1 | Clears `rx_full` |
| sck_in | input | 1 | Serial clock from an external master |
| ss_n_in | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sck_out | output | 1 | Serial clock when master |
| sck_oe | output | 1 | Output enable for `sck_out` |
| sdo | output | 1 | Serial data out |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Receive register holds an unacknowledged byte |
| busy | output | 1 | A byte is in progress |

## Verification
The properties assume that the configuration inputs stay still while a byte is in flight. In slave mode they assume that `sck_in`, `ss_n_in` and `sdi` change slowly compared with the system clock, at least eight clocks per half period. The output hold-off is assumed to be shorter than half a serial period. The stimulus changes configuration only between bytes and drives the external clock with eight-clock half periods. It uses the longest output delays only with master rates whose half period exceeds them. In slave mode it presents each `sdi` bit at the returning clock edge and holds it through the next leaving edge.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned EDGE_W = $clog2(2 * BYTE_W);
    localparam int unsigned LAST_EDGE = 2 * BYTE_W - 1;

    typedef struct packed {
        logic              run;
        logic              armed;
        logic              sck;
        logic [EDGE_W-1:0] edges;
        logic [BYTE_W-1:0] sh;
        logic              smp;
        logic [BYTE_W-1:0] rx;
        logic              full;
    } xcvr_st_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int unsigned W = 3,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = a;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST;
            s2_q <= RST;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign y = s2_q;
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned CW = (1 << SEL_W) - 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        last  = CW'((1 << sel) - 1);
        tick  = run && (cnt_q == last);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_sdo_dly.sv
module spi_sdo_dly #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d,
    input  logic [SEL_W-1:0] sel,
    output logic             q
);
    localparam int unsigned TAPS = (1 << SEL_W) - 1;

    logic [TAPS-1:0] pipe_d, pipe_q;
    logic [SEL_W-1:0] idx;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        if (i == 0) begin : g_head
            assign pipe_d[i] = d;
        end else begin : g_body
            assign pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    always_comb begin
        idx = sel - SEL_W'(1);
        q   = (sel == '0) ? d : pipe_q[idx];
    end
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
    import spi_xcvr_pkg::*;
#(
    parameter int unsigned DIV_W = 2,
    parameter int unsigned DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_master,
    input  logic             cfg_four_wire,
    input  logic             cfg_cpol,
    input  logic             cfg_lsb_first,
    input  logic             cfg_sdo_idle,
    input  logic [DLY_W-1:0] cfg_sdo_dly,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [7:0]       tx_data,
    input  logic             tx_start,
    input  logic             rd_ack,
    input  logic             sck_in,
    input  logic             ss_n_in,
    input  logic             sdi,
    output logic             sck_out,
    output logic             sck_oe,
    output logic             sdo,
    output logic [7:0]       rx_data,
    output logic             rx_full,
    output logic             busy
);
    xcvr_st_t q, n;
    logic tick, lead, trail, done, chg, samp, sdo_raw;
    logic sck_s, ss_s, sdi_s;

    // external pins resynchronised for slave operation
    spi_sync #(.W(3), .RST(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .a     ({sck_in, ss_n_in, sdi}),
        .y     ({sck_s, ss_s, sdi_s})
    );

    spi_clkdiv #(.SEL_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.run && cfg_master),
        .sel   (cfg_div),
        .tick  (tick)
    );

    always_comb begin
        n     = q;
        lead  = 1'b0;
        trail = 1'b0;
        done  = 1'b0;
        chg   = 1'b0;
        samp  = sdi;
        if (cfg_master) begin
            if (!q.run) begin
                n.sck = cfg_cpol;
                if (tx_start) begin
                    n.run   = 1'b1;
                    n.armed = 1'b1;
                    n.sh    = tx_data;
                    n.edges = '0;
                end
            end else if (tick) begin
                n.sck = ~q.sck;
                lead  = ~q.edges[0];
                trail = q.edges[0];
            end
        end else begin
            samp  = sdi_s;
            n.run = 1'b0;
            n.sck = sck_s;
            chg   = (sck_s != q.sck);
            if (cfg_four_wire && ss_s) begin
                n.edges = '0;       // deselected: abort and hold count at zero
            end else begin
                lead  = chg && (sck_s != cfg_cpol) && !q.edges[0];
                trail = chg && (sck_s == cfg_cpol) && q.edges[0];
            end
            if (tx_start && (q.edges == '0)) begin
                n.armed = 1'b1;
                n.sh    = tx_data;
            end
        end

        if (lead) begin
            n.smp   = samp;
            n.edges = q.edges + EDGE_W'(1);
        end
        if (trail) begin
            n.edges = q.edges + EDGE_W'(1);
            n.sh    = cfg_lsb_first ? {q.smp, q.sh[BYTE_W-1:1]}
                                    : {q.sh[BYTE_W-2:0], q.smp};
            if (q.edges == EDGE_W'(LAST_EDGE)) begin
                done    = 1'b1;
                n.armed = 1'b0;
                n.run   = 1'b0;
                n.rx    = n.sh;
            end
        end
        if (rd_ack) n.full = 1'b0;
        if (done)   n.full = 1'b1;

        sdo_raw = q.armed ? (cfg_lsb_first ? q.sh[0] : q.sh[BYTE_W-1])
                          : cfg_sdo_idle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    spi_sdo_dly #(.SEL_W(DLY_W)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sdo_raw),
        .sel   (cfg_sdo_dly),
        .q     (sdo)
    );

    assign sck_out = cfg_master ? q.sck : cfg_cpol;
    assign sck_oe  = cfg_master;
    assign rx_data = q.rx;
    assign rx_full = q.full;
    assign busy    = cfg_master ? q.run : (q.edges != '0);
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk #(
    parameter int unsigned DIV_W = 2,
    parameter int unsigned DLY_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_master,
    input logic             cfg_four_wire,
    input logic             cfg_cpol,
    input logic             cfg_lsb_first,
    input logic             cfg_sdo_idle,
    input logic [DLY_W-1:0] cfg_sdo_dly,
    input logic [DIV_W-1:0] cfg_div,
    input logic [7:0]       tx_data,
    input logic             tx_start,
    input logic             rd_ack,
    input logic             sck_in,
    input logic             ss_n_in,
    input logic             sdi,
    input logic             sck_out,
    input logic             sck_oe,
    input logic             sdo,
    input logic [7:0]       rx_data,
    input logic             rx_full,
    input logic             busy
);
    logic [2:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end

    p_sck_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd2) && cfg_master && $past(cfg_master) && !busy && !$past(busy)
        && $stable(cfg_cpol) |-> sck_out == cfg_cpol);

    p_sck_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd2) && cfg_master && busy && (cfg_div != '0) && $stable(cfg_div)
        && (sck_out != $past(sck_out)) |=> $stable(sck_out));

    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !rd_ack |=> rx_full);

    p_rx_on_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd1) && !$stable(rx_data) |-> rx_full);

    p_sdo_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd4) && cfg_master && $past(cfg_master, 3)
        && !busy && !$past(busy, 1) && !$past(busy, 2) && !$past(busy, 3)
        && (cfg_sdo_idle == $past(cfg_sdo_idle, 1))
        && (cfg_sdo_idle == $past(cfg_sdo_idle, 2))
        && (cfg_sdo_idle == $past(cfg_sdo_idle, 3))
        |-> sdo == cfg_sdo_idle);

    p_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd4) && !cfg_master && !$past(cfg_master, 3)
        && cfg_four_wire && $past(cfg_four_wire, 3)
        && $past(ss_n_in, 2) && $past(ss_n_in, 3) |-> !busy);
endmodule

bind spi_xcvr spi_xcvr_chk #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_chk (.*);

// File: tb/test_spi_xcvr.sv
module test_spi_xcvr;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_master = 1'b1, cfg_four_wire = 1'b0, cfg_cpol = 1'b0;
    logic cfg_lsb_first = 1'b0, cfg_sdo_idle = 1'b0;
    logic [1:0] cfg_sdo_dly = 2'd0, cfg_div = 2'd0;
    logic [7:0] tx_data = 8'h00;
    logic tx_start = 1'b0, rd_ack = 1'b0;
    logic sck_in = 1'b0, ss_n_in = 1'b1, sdi_sl = 1'b0;
    logic sdi_m = 1'b0;
    logic sdi;
    logic sck_out, sck_oe, sdo, rx_full, busy;
    logic [7:0] rx_data;

    assign sdi = cfg_master ? sdi_m : sdi_sl;

    always #2 clk = ~clk;

    spi_xcvr i_spi_xcvr (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_four_wire(cfg_four_wire),
        .cfg_cpol(cfg_cpol), .cfg_lsb_first(cfg_lsb_first), .cfg_sdo_idle(cfg_sdo_idle),
        .cfg_sdo_dly(cfg_sdo_dly), .cfg_div(cfg_div), .tx_data(tx_data), .tx_start(tx_start),
        .rd_ack(rd_ack), .sck_in(sck_in), .ss_n_in(ss_n_in), .sdi(sdi), .sck_out(sck_out),
        .sck_oe(sck_oe), .sdo(sdo), .rx_data(rx_data), .rx_full(rx_full), .busy(busy)
    );

    int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
    logic [7:0] sb_q[$];

    function automatic logic bitof(input logic [7:0] b, input int i, input logic lsb);
        return lsb ? b[i] : b[7-i];
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // scoreboard monitor: every rise of rx_full must match the next queued byte
    logic mon_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && rx_full && !mon_prev) begin
            mon_checks++;
            if (sb_q.size() == 0) begin
                mon_fails++;
                $display("FAIL R7/R11 unexpected byte actual=%0h expected=none", rx_data);
            end else begin
                logic [7:0] want_rx;
                want_rx = sb_q.pop_front();
                if (rx_data !== want_rx) begin
                    mon_fails++;
                    $display("FAIL R1 rx_data actual=%0h expected=%0h", rx_data, want_rx);
                end
            end
        end
        mon_prev = rx_full;
    end

    // far-end slave model used while the block is master
    logic [7:0] m_byte = 8'h00, m_cap = 8'h00;
    int m_nlead = 0, m_bi = 0, m_per = 0, m_last = 0, cyc_n = 0;
    logic m_psck = 1'b0, m_pbusy = 1'b0;
    always @(negedge clk) begin
        cyc_n++;
        if (cfg_master && busy && !m_pbusy) begin
            m_cap = 8'h00; m_nlead = 0; m_bi = 0;
            sdi_m = bitof(m_byte, 0, cfg_lsb_first);
        end
        if (cfg_master && (sck_out != m_psck)) begin
            if (sck_out != cfg_cpol) begin
                m_cap = {m_cap[6:0], sdo};
                m_nlead++;
                m_per = cyc_n - m_last;
                m_last = cyc_n;
            end else begin
                m_bi++;
                if (m_bi < 8) sdi_m = bitof(m_byte, m_bi, cfg_lsb_first);
            end
        end
        m_psck = sck_out;
        m_pbusy = busy;
    end

    task automatic m_xfer(input logic [7:0] tx, input logic [7:0] rsp, input string tag,
                          input bit poke, input bit meas);
        logic [7:0] want;
        logic ps, pk;
        int n;
        m_byte = rsp;
        sb_q.push_back(rsp);
        @(negedge clk); tx_data = tx; tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        check(busy === 1'b1, "R1 busy after start", busy, 1);
        if (meas) begin
            ps = sdo; pk = sck_out;
            forever begin
                @(negedge clk);
                if (sck_out != pk && sck_out == cfg_cpol) break;
                ps = sdo; pk = sck_out;
            end
            n = 0;
            while (sdo == ps && n < 20) begin @(negedge clk); n++; end
            check(n == int'(cfg_sdo_dly), "R6 sdo delay", n, cfg_sdo_dly);
        end
        if (poke) begin
            repeat (6) @(negedge clk);
            tx_data = 8'hFF; tx_start = 1'b1;
            @(negedge clk); tx_start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        want = cfg_lsb_first ? rev8(tx) : tx;
        check(m_cap == want, tag, m_cap, want);
        check(m_nlead == 8, "R2 pulse count", m_nlead, 8);
        check(m_per == (2 << cfg_div), "R2 sck period", m_per, 2 << cfg_div);
        check(sdo == cfg_sdo_idle, "R5 sdo after byte", sdo, cfg_sdo_idle);
        check(rx_full === 1'b1, "R7 full held", rx_full, 1);
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
        check(rx_full === 1'b0, "R7 cleared by ack", rx_full, 0);
    endtask

    localparam int H = 8;

    task automatic s_clock(input int nbits, input logic [7:0] mb, output logic [7:0] cap);
        cap = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            cap = {cap[6:0], sdo};
            sck_in = ~cfg_cpol;
            repeat (H) @(negedge clk);
            sck_in = cfg_cpol;
            if (i < 7) sdi_sl = bitof(mb, i + 1, cfg_lsb_first);
            repeat (H) @(negedge clk);
        end
    endtask

    task automatic s_xfer(input logic [7:0] tx, input logic [7:0] mb, input string tag);
        logic [7:0] cap, want;
        sb_q.push_back(mb);
        @(negedge clk); tx_data = tx; tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        sdi_sl = bitof(mb, 0, cfg_lsb_first);
        if (cfg_four_wire) ss_n_in = 1'b0;
        repeat (H) @(negedge clk);
        s_clock(8, mb, cap);
        repeat (4) @(negedge clk);
        want = cfg_lsb_first ? rev8(tx) : tx;
        check(cap == want, tag, cap, want);
        check(rx_full === 1'b1, "R7 slave fill", rx_full, 1);
        check(sdo == cfg_sdo_idle, "R5 slave sdo after byte", sdo, cfg_sdo_idle);
        check(busy === 1'b0, "R8 slave idle after byte", busy, 0);
        ss_n_in = 1'b1;
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
    endtask

    task automatic run_all();
        logic [7:0] cap;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(rx_full === 1'b0, "R7 reset full", rx_full, 0);
        check(busy === 1'b0, "R1 reset busy", busy, 0);
        check(sck_out === 1'b0, "R2 reset sck rest", sck_out, 0);
        check(sdo === 1'b0, "R5 reset sdo", sdo, 0);

        m_xfer(8'hA5, 8'h3C, "R1 msb master", 0, 0);
        cfg_lsb_first = 1'b1; cfg_div = 2'd1;
        m_xfer(8'h81, 8'h17, "R4 lsb master", 0, 0);
        cfg_cpol = 1'b1; cfg_div = 2'd2; cfg_sdo_idle = 1'b1; cfg_sdo_dly = 2'd2;
        repeat (4) @(negedge clk);
        check(sck_out === 1'b1, "R2 rest level cpol1", sck_out, 1);
        m_xfer(8'hC6, 8'h5A, "R3 cpol1 master", 0, 0);
        cfg_cpol = 1'b0; cfg_lsb_first = 1'b0; cfg_sdo_idle = 1'b0;
        for (int d = 0; d < 4; d++) begin
            cfg_div = 2'd3; cfg_sdo_dly = 2'(d);
            repeat (4) @(negedge clk);
            m_xfer(8'h55, 8'hE1, "R6 pattern", 0, 1);
        end
        cfg_div = 2'd0; cfg_sdo_dly = 2'd0;
        m_xfer(8'h96, 8'h69, "R11 restart ignored", 1, 0);

        // slave, 4-wire
        sck_in = cfg_cpol;
        cfg_master = 1'b0; cfg_four_wire = 1'b1; cfg_sdo_dly = 2'd3;
        repeat (4) @(negedge clk);
        check(sck_oe === 1'b0, "R8 sck_oe low in slave", sck_oe, 0);
        s_xfer(8'h2B, 8'hD4, "R8 slave msb");
        cfg_cpol = 1'b1; sck_in = 1'b1; cfg_lsb_first = 1'b1; cfg_sdo_idle = 1'b1;
        repeat (4) @(negedge clk);
        s_xfer(8'h4E, 8'h93, "R4 slave lsb cpol1");

        // abort mid-byte
        @(negedge clk); tx_data = 8'h11; tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        ss_n_in = 1'b0; sdi_sl = 1'b1;
        repeat (H) @(negedge clk);
        s_clock(3, 8'hFF, cap);
        ss_n_in = 1'b1;
        repeat (6) @(negedge clk);
        check(busy === 1'b0, "R9 abort clears count", busy, 0);
        check(rx_full === 1'b0, "R9 abort no fill", rx_full, 0);
        // edges while deselected
        s_clock(3, 8'hFF, cap);
        repeat (6) @(negedge clk);
        check(busy === 1'b0, "R9 edges ignored deselected", busy, 0);
        s_xfer(8'h7C, 8'h0F, "R9 full byte after abort");

        // 3-wire: select stays high
        cfg_four_wire = 1'b0; cfg_cpol = 1'b0; sck_in = 1'b0; cfg_lsb_first = 1'b0;
        repeat (4) @(negedge clk);
        s_xfer(8'hB2, 8'h6D, "R10 three-wire");
        repeat (10) @(negedge clk);
        check(sb_q.size() == 0, "R7 all bytes delivered", sb_q.size(), 0);
    endtask

    initial begin
        run_all();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + mon_checks, fails + mon_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end
endmodule